// File: doc/BRIEF.md
# Subvector-Predicated Vector Adder

This block adds two vectors held in an element-addressable storage and writes the sums into a third vector in the same storage. Scalars are gathered into groups of one to four, and each group is treated as a single element. The vector length therefore counts groups rather than scalars, and a single predicate bit decides whether the whole group is written.

A command is accepted on the cycle `cmd_start` is high while the block is idle. The command carries the group count, the group size, the element width, three base addresses and a predicate word with an invert flag. The group size comes only from the command field; there is no stored group-size setting. The block then handles one group per clock. It presents the two source addresses to a pair of group-wide read ports, each returning the scalars at the address and the scalars that follow it. It drives the sums onto a group-wide write port with one enable bit per lane. `done` pulses for one cycle after the last group.

The storage is expected to answer reads combinationally and to commit a write at the clock edge that ends the cycle in which `wr_en` is high. The add wraps at the chosen width and has no carry or overflow output.

Top module: `sv_group_adder`

## Requirements
- R1: After a synchronous active-low reset, `busy`, `done` and `wr_en` are all low.
- R2: With group size S = `cmd_subvl_m1` + 1, group i reads at `cmd_rs1_base` + i*S and `cmd_rs2_base` + i*S. It writes at `cmd_rd_base` + i*S with `wr_lane_en` bits 0..S-1 set and the rest clear. Lane j of each port carries the scalar at that address + j.
- R3: Each written scalar is (rs1 + rs2) mod 2^W. The width code in `cmd_ew` selects W: 0 gives 8, 1 gives 16, 2 and 3 give 32. Result bits at and above W are zero, and source bits at and above W have no effect.
- R4: Bit i of `cmd_pred` governs group i. The group is written when that bit XOR `cmd_pred_inv` is 1. A disabled group produces no write, so its destination scalars keep their old values.
- R5: One group is handled per clock. `busy` is high for exactly VL cycles after the accepting edge. `done` is high for one cycle, seen after the VL-th edge that follows the accepting edge.
- R6: A command with VL = 0 writes nothing, and `done` pulses in the cycle right after the accepting edge.
- R7: `cmd_start` while `busy` is high is ignored: the running command is unchanged and the ignored command writes nothing.
- R8: A VL above MAX_VL (16) is treated as MAX_VL.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_start | input | 1 | Accept a command when idle |
| cmd_vl | input | 5 | Number of groups |
| cmd_subvl_m1 | input | 2 | Group size minus one |
| cmd_ew | input | 2 | Element width code |
| cmd_rd_base | input | 8 | Destination base address |
| cmd_rs1_base | input | 8 | First source base address |
| cmd_rs2_base | input | 8 | Second source base address |
| cmd_pred | input | 16 | Predicate word, bit i for group i |
| cmd_pred_inv | input | 1 | Invert predicate sense |
| rd_addr_a | output | 8 | First source read address |
| rd_data_a | input | 128 | First source scalars, lane j at address + j |
| rd_addr_b | output | 8 | Second source read address |
| rd_data_b | input | 128 | Second source scalars, lane j at address + j |
| wr_en | output | 1 | Group write strobe |
| wr_addr | output | 8 | Destination address of lane 0 |
| wr_lane_en | output | 4 | Per-lane write enables |
| wr_data | output | 128 | Sums, lane j for address + j |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The hardest case to reach from the ports is a start pulse that arrives in the middle of a running command. The stimulus raises `cmd_start` at the third busy cycle with a different destination and length. It then confirms that the finish time and every write belong to the first command, and that the intruding destination is untouched. Disabled groups are only visible as scalars that stay the same, so the storage model keeps a shadow copy of every location and compares all of it after each command. Wrap-around is forced by seeding all-ones sources at the 8-bit and 32-bit widths. Clamping of the length is exercised with a length of 20.

// File: rtl/sga_pkg.sv
// Shared types for the grouped vector adder.
// Assumes lanes are at least 32 bits wide so every width code fits.
package sga_pkg;

    typedef enum logic [1:0] {
        EW_8   = 2'd0,
        EW_16  = 2'd1,
        EW_32  = 2'd2,
        EW_32X = 2'd3
    } ew_e;

    // Number of significant bits for a width code.
    function automatic int unsigned ew_bits(ew_e code);
        case (code)
            EW_8:    return 8;
            EW_16:   return 16;
            default: return 32;
        endcase
    endfunction

endpackage

// File: rtl/sga_seq.sv
// Group sequencer: accepts a command while idle, then steps one group per
// clock, advancing the three addresses by the group size and shifting the
// predicate word so bit 0 always belongs to the current group.
// Assumes the caller keeps the accessed regions inside the address space.
module sga_seq #(
    parameter int ADDR_W = 8,
    parameter int MAX_VL = 16,
    parameter int SUB_W  = 2,
    localparam int VL_W  = $clog2(MAX_VL + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cmd_start,
    input  logic [VL_W-1:0]    cmd_vl,
    input  logic [SUB_W-1:0]   cmd_subvl_m1,
    input  logic [1:0]         cmd_ew,
    input  logic [ADDR_W-1:0]  cmd_rd_base,
    input  logic [ADDR_W-1:0]  cmd_rs1_base,
    input  logic [ADDR_W-1:0]  cmd_rs2_base,
    input  logic [MAX_VL-1:0]  cmd_pred,
    input  logic               cmd_pred_inv,
    output logic               busy,
    output logic               done,
    output logic               grp_en,
    output logic [SUB_W-1:0]   sub_m1,
    output sga_pkg::ew_e       ew,
    output logic [ADDR_W-1:0]  rs1_addr,
    output logic [ADDR_W-1:0]  rs2_addr,
    output logic [ADDR_W-1:0]  rd_addr
);
    logic              busy_q, done_q, inv_q;
    logic [VL_W-1:0]   cnt_q, vl_q, vl_eff;
    logic [SUB_W-1:0]  sub_q;
    sga_pkg::ew_e      ew_q;
    logic [MAX_VL-1:0] pred_q;
    logic [ADDR_W-1:0] rs1_q, rs2_q, rd_q, step;

    // Clamp the requested length to the supported maximum.
    always_comb vl_eff = (cmd_vl > VL_W'(MAX_VL)) ? VL_W'(MAX_VL) : cmd_vl;

    // Address stride equals the latched group size.
    always_comb step = ADDR_W'(sub_q) + ADDR_W'(1);

    // Command capture and per-group stepping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            done_q <= 1'b0;
            inv_q  <= 1'b0;
            cnt_q  <= '0;
            vl_q   <= '0;
            sub_q  <= '0;
            ew_q   <= sga_pkg::EW_8;
            pred_q <= '0;
            rs1_q  <= '0;
            rs2_q  <= '0;
            rd_q   <= '0;
        end else begin
            done_q <= 1'b0;
            if (!busy_q && cmd_start) begin
                vl_q   <= vl_eff;
                sub_q  <= cmd_subvl_m1;
                ew_q   <= sga_pkg::ew_e'(cmd_ew);
                pred_q <= cmd_pred;
                inv_q  <= cmd_pred_inv;
                rs1_q  <= cmd_rs1_base;
                rs2_q  <= cmd_rs2_base;
                rd_q   <= cmd_rd_base;
                cnt_q  <= '0;
                if (vl_eff == '0) done_q <= 1'b1;
                else              busy_q <= 1'b1;
            end else if (busy_q) begin
                rs1_q  <= rs1_q + step;
                rs2_q  <= rs2_q + step;
                rd_q   <= rd_q + step;
                pred_q <= pred_q >> 1;
                cnt_q  <= cnt_q + 1'b1;
                if (cnt_q == vl_q - 1'b1) begin
                    busy_q <= 1'b0;
                    done_q <= 1'b1;
                end
            end
        end
    end

    assign busy     = busy_q;
    assign done     = done_q;
    assign grp_en   = pred_q[0] ^ inv_q;
    assign sub_m1   = sub_q;
    assign ew       = ew_q;
    assign rs1_addr = rs1_q;
    assign rs2_addr = rs2_q;
    assign rd_addr  = rd_q;

    // R5
    last_grp_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q && cnt_q == vl_q - 1'b1 |=> done_q && !busy_q);
    // R5
    cnt_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q |-> cnt_q < vl_q);
    // R6
    zero_vl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_q && cmd_start && cmd_vl == '0 |=> done_q && !busy_q);
    // R7
    start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q && cmd_start |=> $stable(vl_q) && $stable(sub_q) && $stable(inv_q));
    // R2
    stride_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q && $past(busy_q) |-> rd_q == $past(rd_q) + step);
endmodule

// File: rtl/sga_lane.sv
// One lane of the adder: sums two scalars and clears every bit at or above
// the selected element width, giving wrap-around at that width.
// Assumes DATA_W is at least 32.
module sga_lane #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  sga_pkg::ew_e      ew,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    output logic [DATA_W-1:0] sum
);
    logic [DATA_W-1:0] raw, mask;

    // Full-width sum before truncation.
    always_comb raw = a + b;

    // Per-bit keep mask for the chosen width.
    for (genvar k = 0; k < DATA_W; k++) begin : g_mask
        assign mask[k] = (k < sga_pkg::ew_bits(ew));
    end

    assign sum = raw & mask;

    // R3
    low_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
        en |-> sum[7:0] == 8'(a[7:0] + b[7:0]));
    // R3
    narrow_high_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        en && ew == sga_pkg::EW_8 |-> sum[DATA_W-1:8] == '0);
endmodule

// File: rtl/sv_group_adder.sv
// Top of the grouped vector adder: a sequencer walks the groups and a row
// of lanes forms the sums; lanes past the group size are write-disabled.
// Assumes storage reads are combinational and writes commit at the edge.
module sv_group_adder #(
    parameter int DATA_W  = 32,
    parameter int ADDR_W  = 8,
    parameter int MAX_VL  = 16,
    parameter int MAX_SUB = 4,
    localparam int SUB_W  = $clog2(MAX_SUB),
    localparam int VL_W   = $clog2(MAX_VL + 1)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      cmd_start,
    input  logic [VL_W-1:0]           cmd_vl,
    input  logic [SUB_W-1:0]          cmd_subvl_m1,
    input  logic [1:0]                cmd_ew,
    input  logic [ADDR_W-1:0]         cmd_rd_base,
    input  logic [ADDR_W-1:0]         cmd_rs1_base,
    input  logic [ADDR_W-1:0]         cmd_rs2_base,
    input  logic [MAX_VL-1:0]         cmd_pred,
    input  logic                      cmd_pred_inv,
    output logic [ADDR_W-1:0]         rd_addr_a,
    input  logic [MAX_SUB*DATA_W-1:0] rd_data_a,
    output logic [ADDR_W-1:0]         rd_addr_b,
    input  logic [MAX_SUB*DATA_W-1:0] rd_data_b,
    output logic                      wr_en,
    output logic [ADDR_W-1:0]         wr_addr,
    output logic [MAX_SUB-1:0]        wr_lane_en,
    output logic [MAX_SUB*DATA_W-1:0] wr_data,
    output logic                      busy,
    output logic                      done
);
    logic             grp_en;
    logic [SUB_W-1:0] sub_m1;
    sga_pkg::ew_e     ew;

    sga_seq #(.ADDR_W(ADDR_W), .MAX_VL(MAX_VL), .SUB_W(SUB_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_vl(cmd_vl),
        .cmd_subvl_m1(cmd_subvl_m1), .cmd_ew(cmd_ew),
        .cmd_rd_base(cmd_rd_base), .cmd_rs1_base(cmd_rs1_base),
        .cmd_rs2_base(cmd_rs2_base), .cmd_pred(cmd_pred),
        .cmd_pred_inv(cmd_pred_inv), .busy(busy), .done(done),
        .grp_en(grp_en), .sub_m1(sub_m1), .ew(ew),
        .rs1_addr(rd_addr_a), .rs2_addr(rd_addr_b), .rd_addr(wr_addr)
    );

    // Write strobe only for an enabled group of a running command.
    assign wr_en = busy & grp_en;

    for (genvar j = 0; j < MAX_SUB; j++) begin : g_lane
        // Lane j takes part when it lies inside the group.
        assign wr_lane_en[j] = (j <= int'(sub_m1));

        sga_lane #(.DATA_W(DATA_W)) u_lane (
            .clk(clk), .rst_n(rst_n), .en(wr_en & wr_lane_en[j]), .ew(ew),
            .a(rd_data_a[j*DATA_W +: DATA_W]),
            .b(rd_data_b[j*DATA_W +: DATA_W]),
            .sum(wr_data[j*DATA_W +: DATA_W])
        );
    end

    // R4
    wr_only_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> busy);
    // R2
    lane0_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> wr_lane_en[0]);
    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !wr_en);
endmodule

// File: tb/sv_group_adder_bench.sv
`timescale 1ns/1ps
module sv_group_adder_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic         cmd_start = 1'b0, cmd_pred_inv = 1'b0;
    logic [4:0]   cmd_vl = '0;
    logic [1:0]   cmd_subvl_m1 = '0, cmd_ew = '0;
    logic [7:0]   cmd_rd_base = '0, cmd_rs1_base = '0, cmd_rs2_base = '0;
    logic [15:0]  cmd_pred = '0;
    logic [7:0]   rd_addr_a, rd_addr_b, wr_addr;
    logic [127:0] rd_data_a, rd_data_b, wr_data;
    logic [3:0]   wr_lane_en;
    logic         wr_en, busy, done;

    logic [31:0] mem [256];
    logic [31:0] exp_mem [256];
    int checks = 0, errors = 0;

    typedef struct packed {
        logic [7:0]   addr;
        logic [3:0]   lanes;
        logic [127:0] data;
    } wr_item_t;
    wr_item_t exp_q[$];

    sv_group_adder u_sv_group_adder (
        .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_vl(cmd_vl),
        .cmd_subvl_m1(cmd_subvl_m1), .cmd_ew(cmd_ew),
        .cmd_rd_base(cmd_rd_base), .cmd_rs1_base(cmd_rs1_base),
        .cmd_rs2_base(cmd_rs2_base), .cmd_pred(cmd_pred),
        .cmd_pred_inv(cmd_pred_inv), .rd_addr_a(rd_addr_a),
        .rd_data_a(rd_data_a), .rd_addr_b(rd_addr_b), .rd_data_b(rd_data_b),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_lane_en(wr_lane_en),
        .wr_data(wr_data), .busy(busy), .done(done)
    );

    for (genvar j = 0; j < 4; j++) begin : g_rd
        assign rd_data_a[j*32 +: 32] = mem[8'(rd_addr_a + 8'(j))];
        assign rd_data_b[j*32 +: 32] = mem[8'(rd_addr_b + 8'(j))];
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Monitor: pop the next expected write, compare, then commit to storage.
    always @(negedge clk) begin
        if (rst_n && wr_en) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R4 unexpected write", longint'(wr_addr), 0);
            end else begin
                wr_item_t it;
                it = exp_q.pop_front();
                chk(wr_addr == it.addr, "R2 write address", longint'(wr_addr), longint'(it.addr));
                chk(wr_lane_en == it.lanes, "R2 lane enables", longint'(wr_lane_en), longint'(it.lanes));
                for (int j = 0; j < 4; j++)
                    if (it.lanes[j])
                        chk(wr_data[j*32 +: 32] == it.data[j*32 +: 32], "R3 lane sum",
                            longint'(wr_data[j*32 +: 32]), longint'(it.data[j*32 +: 32]));
            end
            for (int j = 0; j < 4; j++)
                if (wr_lane_en[j]) mem[8'(wr_addr + 8'(j))] = wr_data[j*32 +: 32];
        end
    end

    task automatic seed(input int a, input logic [31:0] v);
        mem[a] = v;
        exp_mem[a] = v;
    endtask

    // Driver: compute the expected writes, issue the command, time the finish.
    task automatic run_cmd(input int vl, input int sm1, input int ew, input int rd,
                           input int r1, input int r2, input logic [15:0] pred,
                           input bit inv, input bit intrude, input string tag);
        int s, ve, w, n, bn, bad;
        logic [31:0] m;
        wr_item_t it;
        s  = sm1 + 1;
        ve = (vl > 16) ? 16 : vl;
        w  = (ew == 0) ? 8 : (ew == 1) ? 16 : 32;
        m  = (w == 32) ? 32'hFFFF_FFFF : ((32'd1 << w) - 32'd1);
        for (int g = 0; g < ve; g++) begin
            if (pred[g] ^ inv) begin
                it = '0;
                it.addr = 8'(rd + g*s);
                for (int j = 0; j < s; j++) begin
                    logic [31:0] v;
                    v = (exp_mem[8'(r1 + g*s + j)] + exp_mem[8'(r2 + g*s + j)]) & m;
                    it.lanes[j] = 1'b1;
                    it.data[j*32 +: 32] = v;
                    exp_mem[8'(rd + g*s + j)] = v;
                end
                exp_q.push_back(it);
            end
        end
        @(negedge clk);
        cmd_vl = 5'(vl); cmd_subvl_m1 = 2'(sm1); cmd_ew = 2'(ew);
        cmd_rd_base = 8'(rd); cmd_rs1_base = 8'(r1); cmd_rs2_base = 8'(r2);
        cmd_pred = pred; cmd_pred_inv = inv; cmd_start = 1'b1;
        @(posedge clk);
        #1 cmd_start = 1'b0;
        n = 0; bn = 0;
        while (n < 100) begin
            @(negedge clk);
            if (done) break;
            if (busy) bn++;
            if (intrude && n == 2) begin
                cmd_start = 1'b1; cmd_vl = 5'd1; cmd_rd_base = 8'hF0;
                cmd_pred = 16'hFFFF; cmd_pred_inv = 1'b0;
            end else begin
                cmd_start = 1'b0;
            end
            @(posedge clk);
            n++;
        end
        cmd_start = 1'b0;
        chk(n == ve, {tag, " R5 done timing"}, longint'(n), longint'(ve));
        chk(bn == ve, {tag, " R5 busy cycles"}, longint'(bn), longint'(ve));
        chk(exp_q.size() == 0, {tag, " R4 pending writes"}, longint'(exp_q.size()), 0);
        @(negedge clk);
        chk(!done, {tag, " R5 done one cycle"}, longint'(done), 0);
        bad = 0;
        for (int a = 0; a < 256; a++) if (mem[a] !== exp_mem[a]) bad++;
        chk(bad == 0, {tag, " R4 storage contents"}, longint'(bad), 0);
        exp_q.delete();
    endtask

    initial begin
        #500000;
        chk(1'b0, "watchdog expired", 0, 1);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int a = 0; a < 256; a++) begin
            mem[a] = (32'h9E37_79B9 * 32'(a + 1)) ^ 32'(a << 3);
            exp_mem[a] = mem[a];
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(!busy, "R1 busy after reset", longint'(busy), 0);
        chk(!done, "R1 done after reset", longint'(done), 0);
        chk(!wr_en, "R1 wr_en after reset", longint'(wr_en), 0);
        rst_n = 1'b1;

        // Groups of 3 at 16 bits, inverted predicate: groups 0 and 3 disabled.
        run_cmd(5, 2, 1, 8'h00, 8'h40, 8'h80, 16'h0009, 1'b1, 1'b0, "R4 inverted");
        // Single scalars at 8 bits with wrap-around.
        seed(8'h48, 32'hAB00_00FF); seed(8'h88, 32'h0000_1202);
        run_cmd(6, 0, 0, 8'h10, 8'h48, 8'h88, 16'hFFFF, 1'b0, 1'b0, "R3 width8");
        chk(mem[8'h10] == 32'h01, "R3 8-bit wrap value", longint'(mem[8'h10]), 32'h01);
        // Groups of 4 at 32 bits; group 1 wraps.
        seed(8'h54, 32'hFFFF_FFFF); seed(8'h94, 32'h5);
        run_cmd(4, 3, 2, 8'h20, 8'h50, 8'h90, 16'h000A, 1'b0, 1'b0, "R2 width32");
        chk(mem[8'h24] == 32'h4, "R3 32-bit wrap value", longint'(mem[8'h24]), 32'h4);
        // Zero length.
        run_cmd(0, 1, 1, 8'h30, 8'h40, 8'h80, 16'hFFFF, 1'b0, 1'b0, "R6 zero length");
        // Length 20 clamps to 16 groups of 4.
        run_cmd(20, 3, 1, 8'hA0, 8'h00, 8'h40, 16'h5A5A, 1'b0, 1'b0, "R8 clamp");
        // Start pulse during a running command.
        run_cmd(8, 1, 2, 8'hE0, 8'h10, 8'h20, 16'hFFFF, 1'b0, 1'b1, "R7 ignored start");
        // Width code 3 acts as 32 bits.
        run_cmd(3, 1, 3, 8'hF8, 8'h60, 8'h70, 16'h0005, 1'b1, 1'b0, "R3 code3");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule